// File: doc/BRIEF.md
# Serial Transmitter with In-Word Parity

This block turns parallel words into an asynchronous serial stream. The word length is selected by one configuration bit. It is either 8 or 9 positions long, and that length includes the parity bit when parity is on. Parity is not appended as an extra bit. When enabled, the computed odd or even parity bit overwrites the top position of the word. To send a full byte with parity, choose the 9-position length. With the 8-position length and parity on, only 7 data bits remain.

Words enter through a valid/ready stream port into a one-word holding register. A separate frame shifter takes the held word at a baud tick. This gives a two-word buffer: a new word can wait while the previous one is still on the line.

Back-pressure works as follows. `in_ready` is low while the holding register is occupied. While `in_valid` is high and `in_ready` is low, the source must keep `in_data` stable. A transfer happens on a rising clock edge where both signals are high.

The frame shifter samples length, parity and stop-bit settings when it loads a word. A setting changed mid-frame therefore applies only from the next frame on.

Top module: `utx_core`

## Requirements
- R1: After reset, `txd` is high and both `tx_empty` and `in_ready` are high.
- R2: A word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` equals `tx_empty`. While it is low, no word is taken and the held word is kept.
- R3: A held word is loaded into the shifter on a `baud_tick` cycle. The line goes low (start bit) from the next cycle. After that, each `baud_tick` advances the line by one bit, least significant bit first. Between ticks the line does not change.
- R4: With `cfg_len9`=0 a frame carries word bits 0..7. With `cfg_len9`=1 it carries word bits 0..8.
- R5: One stop bit follows the word when `cfg_stop2`=0, and two stop bits follow it when `cfg_stop2`=1. Stop bits and the idle line are high.
- R6: With `cfg_len9`=1 and `cfg_par_en`=1, position 8 carries the parity of `in_data[7:0]`. `in_data[8]` is not sent.
- R7: With `cfg_len9`=0 and `cfg_par_en`=1, position 7 carries the parity of `in_data[6:0]`. `in_data[7]` is not sent.
- R8: The parity bit makes the total number of ones in the covered data bits plus parity even when `cfg_par_odd`=0, and odd when it is 1.
- R9: `tx_empty` rises in the cycle after the held word moves into the shifter. A second word can then be accepted while the first is still being sent.
- R10: Length, stop count and parity settings are sampled when a word is loaded. Changing them mid-frame leaves the frame in progress unchanged.
- R11: When a word is waiting, the tick that ends the last stop bit loads it directly. The next start bit follows with no idle bit time in between.
- R12: With `cfg_par_en`=0, all word positions carry `in_data` unchanged. With `cfg_len9`=0, `in_data[8]` has no effect on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| in_valid | input | 1 | Source has a word |
| in_ready | output | 1 | Holding register can take a word |
| in_data | input | 9 | Word to send, bit 0 first |
| cfg_len9 | input | 1 | 0: 8 word positions, 1: 9 word positions |
| cfg_par_en | input | 1 | Parity overwrites the top word position |
| cfg_par_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_stop2 | input | 1 | 0: one stop bit, 1: two stop bits |
| txd | output | 1 | Serial line, idle high |
| tx_empty | output | 1 | Holding register is empty |

## Verification
Two events can land on the same clock edge: the final stop-bit tick of one frame and the load of the next waiting word. A third can sit close by: the acceptance of a further word in the cycle after the register frees.

The bench provokes this by pushing words back to back with the source holding `in_valid` high. Words therefore queue behind the shifter, and some settings are flipped in the middle of frames.

A behavioural queue model of the line predicts `txd`, `tx_empty` and `in_ready` on every clock. A lost word, an idle gap, a late empty flag, or a frame that picks up a mid-frame setting all show up as a mismatch on the exact cycle where they occur.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int unsigned WORD_W  = 9;
  localparam int unsigned FRAME_W = WORD_W + 3;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic len9;
    logic par_en;
    logic par_odd;
    logic stop2;
  } cfg_t;
endpackage

// File: rtl/utx_parity.sv
module utx_parity #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] bits,
  input  logic         odd,
  output logic         par
);
  // Even: xor of data makes the total even; odd: inverted.
  assign par = (^bits) ^ odd;
endmodule

// File: rtl/utx_wordfmt.sv
module utx_wordfmt
  import utx_pkg::*;
(
  input  logic [WORD_W-1:0] data,
  input  cfg_t              cfg,
  output logic [WORD_W-1:0] word
);
  logic par_long, par_short;

  utx_parity #(.W(WORD_W-1)) u_par_long (
    .bits(data[WORD_W-2:0]), .odd(cfg.par_odd), .par(par_long));
  utx_parity #(.W(WORD_W-2)) u_par_short (
    .bits(data[WORD_W-3:0]), .odd(cfg.par_odd), .par(par_short));

  always_comb begin
    word = data;
    if (cfg.len9) begin
      if (cfg.par_en) word[WORD_W-1] = par_long;
    end else begin
      word[WORD_W-1] = 1'b1;
      if (cfg.par_en) word[WORD_W-2] = par_short;
    end
  end
endmodule

// File: rtl/utx_holdreg.sv
module utx_holdreg #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         hold_full,
  output logic [W-1:0] hold_data
);
  assign in_ready = !hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (in_valid && in_ready) begin
      hold_full <= 1'b1;
      hold_data <= in_data;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  // R2: a held word stays put until the shifter takes it
  a_r2_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !take) |=> (hold_full && $stable(hold_data)));
  // R9: the shifter only takes a word that is present
  a_r9_take_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> hold_full);
  // R9: after a take the register reports empty
  a_r9_empty_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !hold_full);
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              hold_full,
  input  logic [WORD_W-1:0] word,
  input  cfg_t              cfg,
  output logic              take,
  output logic              txd
);
  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   left;
  logic               busy;
  logic               last;
  logic [FRAME_W-1:0] frame_vec;
  logic [CNT_W-1:0]   frame_len;

  assign last = busy && (left == CNT_W'(1));
  assign take = baud_tick && hold_full && (!busy || last);

  always_comb begin
    if (cfg.len9) frame_vec = {2'b11, word, 1'b0};
    else          frame_vec = {3'b111, word[WORD_W-2:0], 1'b0};
    frame_len = CNT_W'(FRAME_W - 2) + CNT_W'(cfg.len9) + CNT_W'(cfg.stop2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr   <= '1;
      left <= '0;
      busy <= 1'b0;
    end else if (take) begin
      sr   <= frame_vec;
      left <= frame_len;
      busy <= 1'b1;
    end else if (baud_tick && busy) begin
      if (last) begin
        sr   <= '1;
        left <= '0;
        busy <= 1'b0;
      end else begin
        sr   <= {1'b1, sr[FRAME_W-1:1]};
        left <= left - CNT_W'(1);
      end
    end
  end

  assign txd = busy ? sr[0] : 1'b1;

  // R3: the line only moves on a baud tick
  a_r3_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd));
  // R3: a load is followed by the start bit
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!txd && busy));
  // R3: bit counter holds between ticks
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> $stable(left));
  // R11: a waiting word follows the last stop bit with no gap
  a_r11_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (last && baud_tick && hold_full) |=> (busy && !txd));
endmodule

// File: rtl/utx_core.sv
module utx_core
  import utx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              cfg_len9,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  output logic              txd,
  output logic              tx_empty
);
  cfg_t              cfg;
  logic              take;
  logic              hold_full;
  logic [WORD_W-1:0] hold_data;
  logic [WORD_W-1:0] word;

  assign cfg = '{len9: cfg_len9, par_en: cfg_par_en,
                 par_odd: cfg_par_odd, stop2: cfg_stop2};

  utx_holdreg #(.W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .take(take), .hold_full(hold_full),
    .hold_data(hold_data));

  utx_wordfmt u_fmt (.data(hold_data), .cfg(cfg), .word(word));

  utx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .hold_full(hold_full),
    .word(word), .cfg(cfg), .take(take), .txd(txd));

  assign tx_empty = !hold_full;

  // R1: idle line is high whenever nothing was ever loaded
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && !$past(take)) |-> txd);
endmodule

// File: tb/tb_utx_core.sv
module tb_utx_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [8:0] in_data = '0;
  logic       cfg_len9 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic       txd, tx_empty;

  always #4 clk = ~clk;

  utx_core dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .cfg_len9(cfg_len9),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
    .txd(txd), .tx_empty(tx_empty));

  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";
  bit    m_full = 0;
  logic [8:0] m_word = '0;
  bit    q[$];
  int    tick_cnt = 0;

  // baud tick every 4 cycles
  always @(negedge clk) begin
    tick_cnt  = (tick_cnt + 1) % 4;
    baud_tick = (tick_cnt == 0);
  end

  function automatic void build(input logic [8:0] d);
    int nw, ones;
    bit b;
    nw = cfg_len9 ? 9 : 8;
    q.push_back(1'b0);
    ones = 0;
    for (int i = 0; i < nw - 1; i++) ones += d[i];
    for (int i = 0; i < nw; i++) begin
      b = d[i];
      if (cfg_par_en && i == nw - 1) b = cfg_par_odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
      q.push_back(b);
    end
    q.push_back(1'b1);
    if (cfg_stop2) q.push_back(1'b1);
  endfunction

  always @(posedge clk) begin
    bit acc;
    if (!rst_n) begin
      m_full = 0;
      q.delete();
    end else begin
      acc = in_valid && !m_full;
      if (baud_tick) begin
        if (q.size() > 0) void'(q.pop_front());
        if (q.size() == 0 && m_full) begin
          build(m_word);
          m_full = 0;
        end
      end
      if (acc) begin
        m_full = 1;
        m_word = in_data;
      end
    end
  end

  task automatic cmp(input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cmp("txd", txd, (q.size() > 0) ? q[0] : 1'b1);
      cmp("tx_empty", tx_empty, !m_full);
      cmp("in_ready", in_ready, !m_full);
    end
  end

  task automatic push(input logic [8:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 9'h0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (q.size() != 0 || m_full) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic setcfg(input logic l9, input logic pe, input logic po, input logic s2);
    cfg_len9 = l9; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    repeat (6) @(negedge clk);
    tag = "R12"; setcfg(0, 0, 0, 0); push(9'h1A5); drain();    // R4 len 8, bit 8 ignored
    tag = "R4";  setcfg(1, 0, 0, 0); push(9'h13C); drain();
    tag = "R6";  setcfg(1, 1, 0, 0); push(9'h0F3); push(9'h101); drain();
    tag = "R8";  setcfg(1, 1, 1, 0); push(9'h0F3); push(9'h000); drain();
    tag = "R7";  setcfg(0, 1, 0, 0); push(9'h0FF); push(9'h080); drain();
    tag = "R8";  setcfg(0, 1, 1, 0); push(9'h07F); push(9'h055); drain();
    tag = "R5";  setcfg(1, 0, 0, 1); push(9'h0AA); drain();
    setcfg(0, 1, 1, 1); push(9'h033); drain();
    tag = "R9";  setcfg(0, 0, 0, 0);
    push(9'h011); push(9'h022); push(9'h044); drain();
    tag = "R11"; setcfg(1, 1, 0, 1);
    for (int i = 0; i < 6; i++) push(9'(i * 37 + 5));
    drain();
    tag = "R10"; setcfg(1, 1, 0, 0); push(9'h0C3);
    repeat (10) @(negedge clk); setcfg(0, 0, 1, 1);
    repeat (12) @(negedge clk); setcfg(1, 1, 1, 0);
    drain();
    tag = "R2";  setcfg(0, 1, 0, 0);
    push(9'h0E1); push(9'h01E); push(9'h1FF); push(9'h100); drain();
    tag = "R3";  setcfg(1, 0, 0, 0); push(9'h001); push(9'h100); drain();
    summary();
    $finish;
  end
endmodule